// File: doc/BRIEF.md
# Dual-Width Nibble Data RAM

A synchronous data memory of 4-bit words spanning 5,120 locations (addresses 0x0000 to 0x13FF). Every location can be read or written one nibble at a time. One fixed window, 0x0100 to 0x01FF, also accepts 16-bit accesses that move four adjacent nibbles at once. Stack traffic that uses the wide stack pointer relies on these accesses. Everything else in the processor issues nibble accesses only.

A request is presented for one cycle with `en` high. `we` selects write, `wide` selects a 16-bit access, and `addr` gives the nibble address. Results are registered. Read data and the error flag appear in the cycle after the request. Three kinds of request are refused: a wide access that falls outside the window, a wide access that is not aligned, and any access above the top of the memory. A refused request raises the error flag, returns zero and leaves the memory untouched.

Internally the storage is split into four nibble lanes indexed by the low two address bits. A wide access therefore touches one row of every lane in a single cycle, and each lane maps onto a plain block RAM.

Top module: `nib_data_ram`

## Requirements
- R1: After reset, and before any request, `err` is 0 and `rdata` is 0.
- R2: A nibble access (`wide`=0) to any address from 0x0000 to 0x13FF is legal. The cycle after a nibble read, `rdata[3:0]` holds the stored nibble, `rdata[15:4]` is zero, and `err` is 0.
- R3: A wide access (`wide`=1) at an address from 0x0100 to 0x01FF whose two low bits are 00 is legal. Nibble addr+k travels in `rdata`/`wdata` bits [4k+3:4k], for k = 0 to 3.
- R4: Wide and nibble views share the same storage. Four nibble writes read back together as one wide word, and a wide write reads back as four separate nibbles.
- R5: A wide access whose address lies outside 0x0100 to 0x01FF raises `err` in the next cycle and returns `rdata` = 0. A wide write of this kind changes no location.
- R6: A wide access inside the window whose two low address bits are not 00 raises `err` in the next cycle, returns zero and changes no location.
- R7: Any access to an address above 0x13FF raises `err` in the next cycle, returns zero and changes no location.
- R8: A legal write also returns, in the next cycle, the contents the addressed location(s) held before that write.
- R9: The cycle after a cycle with `en`=0, `err` is 0 and `rdata` is 0.
- R10: The window edges are exact. Wide accesses at 0x0100 and 0x01FC are legal. Wide accesses at 0x00FC and 0x0200 are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Request strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 16-bit access, 0 = nibble access |
| addr | input | 16 | Nibble address |
| wdata | input | 16 | Write data; nibble writes use bits [3:0] |
| rdata | output | 16 | Registered read data, one cycle after the request |
| err | output | 1 | Registered refusal flag, one cycle after the request |

## Verification
The bench probes the window edges at 0x00FC, 0x0100, 0x01FC and 0x0200. A design with an off-by-one window bound would accept or refuse the wrong one of these. It issues a misaligned wide write inside the window and then reads the row back. A design that ignores alignment would corrupt two rows or rotate the nibble order. It writes to 0x1400 and checks that 0x0000 and 0x13FF still hold their values, which catches address aliasing into the top rows. Each write also returns its old data, and the bench compares it against the reference model. A write-first memory would return the new value instead.

// File: rtl/nram_pkg.sv
package nram_pkg;
  // Decoded request, carried one stage to steer the read result.
  typedef struct packed {
    logic       ok;
    logic       wide;
    logic [1:0] lane;
  } nram_acc_t;
endpackage

// File: rtl/nram_decode.sv
module nram_decode
  import nram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 5120,
  parameter int WIN_LO = 'h0100,
  parameter int WIN_HI = 'h01FF,
  parameter int LANE_B = 2,
  parameter int ROW_W  = 11
) (
  input  logic              en,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  output nram_acc_t         acc,
  output logic [ROW_W-1:0]  row,
  output logic              err
);
  logic in_range, in_win, aligned, legal;

  always_comb begin
    in_range = ({1'b0, addr} < (ADDR_W+1)'(DEPTH));
    in_win   = ({1'b0, addr} >= (ADDR_W+1)'(WIN_LO)) &&
               ({1'b0, addr} <= (ADDR_W+1)'(WIN_HI));
    aligned  = (addr[LANE_B-1:0] == '0);
    legal    = in_range && (!wide || (in_win && aligned));
    acc.ok   = en && legal;
    acc.wide = wide;
    acc.lane = addr[LANE_B-1:0];
    err      = en && !legal;
    row      = ROW_W'(addr >> LANE_B);
  end
endmodule

// File: rtl/nram_bank.sv
module nram_bank #(
  parameter int NIB_W = 4,
  parameter int ROWS  = 1280,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             re,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [NIB_W-1:0] wd,
  output logic [NIB_W-1:0] rd
);
  logic [NIB_W-1:0] mem [ROWS];

  // Read-first single port: the read captures the value before the write.
  always_ff @(posedge clk) begin
    if (we) mem[row] <= wd;
    if (re) rd <= mem[row];
  end
endmodule

// File: rtl/nram_pack.sv
module nram_pack #(
  parameter int NIB_W  = 4,
  parameter int LANES  = 4,
  parameter int LANE_B = 2
) (
  input  logic [LANES*NIB_W-1:0] lanes_rd,
  input  logic                   ok_q,
  input  logic                   wide_q,
  input  logic [LANE_B-1:0]      lane_q,
  output logic [LANES*NIB_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (ok_q) begin
      if (wide_q) rdata = lanes_rd;
      else        rdata[NIB_W-1:0] = lanes_rd[lane_q*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/nib_data_ram.sv
module nib_data_ram
  import nram_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WIDE_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 5120,
  parameter int WIN_LO = 'h0100,
  parameter int WIN_HI = 'h01FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDE_W-1:0] wdata,
  output logic [WIDE_W-1:0] rdata,
  output logic              err
);
  localparam int LANES  = WIDE_W / NIB_W;
  localparam int LANE_B = $clog2(LANES);
  localparam int ROWS   = DEPTH / LANES;
  localparam int ROW_W  = $clog2(ROWS);

  nram_acc_t          acc, acc_q;
  logic [ROW_W-1:0]   row;
  logic               dec_err, err_q;
  logic [LANES-1:0]   bank_we;
  logic [WIDE_W-1:0]  lanes_rd;

  nram_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .LANE_B(LANE_B), .ROW_W(ROW_W)
  ) u_dec (
    .en(en), .wide(wide), .addr(addr), .acc(acc), .row(row), .err(dec_err)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [NIB_W-1:0] lane_wd;
    assign bank_we[i] = acc.ok && we && (acc.wide || acc.lane == LANE_B'(i));
    assign lane_wd    = acc.wide ? wdata[i*NIB_W +: NIB_W] : wdata[NIB_W-1:0];
    nram_bank #(.NIB_W(NIB_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .re(acc.ok), .we(bank_we[i]), .row(row),
      .wd(lane_wd), .rd(lanes_rd[i*NIB_W +: NIB_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      acc_q <= acc;
      err_q <= dec_err;
    end
  end

  nram_pack #(.NIB_W(NIB_W), .LANES(LANES), .LANE_B(LANE_B)) u_pack (
    .lanes_rd(lanes_rd), .ok_q(acc_q.ok), .wide_q(acc_q.wide),
    .lane_q(acc_q.lane), .rdata(rdata)
  );

  assign err = err_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!err && rdata == '0));

  // R2
  nib_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !wide) |=> (rdata[WIDE_W-1:NIB_W] == '0));

  // R3
  lane_we_shape_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(bank_we) == 0 || $countones(bank_we) == 1 ||
     $countones(bank_we) == LANES));

  // R5
  wide_outside_err_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wide && ({1'b0, addr} < (ADDR_W+1)'(WIN_LO) ||
                    {1'b0, addr} > (ADDR_W+1)'(WIN_HI)))
    |=> (err && rdata == '0));

  // R5
  refused_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> (bank_we == '0));

  // R7
  above_top_err_chk: assert property (@(posedge clk) disable iff (rst)
    (en && {1'b0, addr} >= (ADDR_W+1)'(DEPTH)) |=> (err && rdata == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!err && rdata == '0));
endmodule

// File: tb/nib_data_ram_tb.sv
module nib_data_ram_tb;
  localparam int DEPTH = 5120;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, we = 1'b0, wide = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          chk;
    logic        err;
    logic [15:0] rd;
    string       tag;
  } item_t;
  item_t q[$];

  logic [3:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  nib_data_ram u_dut (
    .clk(clk), .rst(rst), .en(en), .we(we), .wide(wide),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
  );

  task automatic compare(string tag, logic e_act, logic [15:0] d_act,
                         logic e_exp, logic [15:0] d_exp);
    checks++;
    if (e_act !== e_exp || d_act !== d_exp) begin
      fails++;
      $display("FAIL %s: err=%0b rdata=%h expected err=%0b rdata=%h",
               tag, e_act, d_act, e_exp, d_exp);
    end
  endtask

  // Driver: one request per cycle, expected result pushed to the scoreboard.
  task automatic acc(bit e, bit w, bit wd, int a, logic [15:0] d,
                     string tag, bit chk = 1'b1);
    item_t it;
    bit in_range, legal;
    @(negedge clk);
    en = e; we = w; wide = wd; addr = 16'(a); wdata = d;
    in_range = (a < DEPTH);
    legal = in_range && (!wd || (a >= 'h100 && a <= 'h1FF && a % 4 == 0));
    it.chk = chk; it.tag = tag;
    it.err = e && !legal;
    it.rd  = '0;
    if (e && legal) begin
      if (wd) it.rd = {ref_mem[a+3], ref_mem[a+2], ref_mem[a+1], ref_mem[a]};
      else    it.rd = {12'h000, ref_mem[a]};
      if (w) begin
        if (wd) for (int k = 0; k < 4; k++) ref_mem[a+k] = d[k*4 +: 4];
        else    ref_mem[a] = d[3:0];
      end
    end
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    acc(1'b0, 1'b0, 1'b0, 0, 16'h0, tag);
  endtask

  // Monitor: results are valid shortly after the edge that registers them.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) compare(it.tag, err, rdata, it.err, it.rd);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs right after reset
    compare("R1", err, rdata, 1'b0, 16'h0000);

    for (int a = 0; a < DEPTH; a++)
      acc(1, 1, 0, a, 16'((a * 7 + 3) & 15), "fill", 1'b0);

    idle("R9");
    acc(0, 1, 1, 'h0100, 16'hFFFF, "R9");      // en low: write must not land
    acc(1, 0, 1, 'h0100, 16'h0, "R9");

    acc(1, 0, 0, 'h0000, 16'h0, "R2");
    acc(1, 0, 0, 'h13FF, 16'h0, "R2");
    acc(1, 0, 0, 'h0A55, 16'h0, "R2");
    acc(1, 1, 0, 'h0A55, 16'hFFF9, "R8");       // returns old nibble
    acc(1, 0, 0, 'h0A55, 16'h0, "R2");

    acc(1, 1, 1, 'h0100, 16'hBEEF, "R8");       // returns old wide word
    acc(1, 0, 1, 'h0100, 16'h0, "R3");
    for (int k = 0; k < 4; k++) acc(1, 0, 0, 'h0100 + k, 16'h0, "R4");
    acc(1, 1, 0, 'h01F0, 16'h0001, "R4");
    acc(1, 1, 0, 'h01F1, 16'h000A, "R4");
    acc(1, 1, 0, 'h01F2, 16'h0005, "R4");
    acc(1, 1, 0, 'h01F3, 16'h000C, "R4");
    acc(1, 0, 1, 'h01F0, 16'h0, "R4");

    acc(1, 1, 1, 'h01FC, 16'h1234, "R10");
    acc(1, 0, 1, 'h01FC, 16'h0, "R10");
    acc(1, 0, 1, 'h00FC, 16'h0, "R10");
    acc(1, 1, 1, 'h0200, 16'h5A5A, "R10");
    acc(1, 1, 1, 'h0040, 16'h7777, "R5");
    acc(1, 0, 1, 'h1000, 16'h0, "R5");
    for (int k = 0; k < 4; k++) acc(1, 0, 0, 'h0200 + k, 16'h0, "R5");
    for (int k = 0; k < 4; k++) acc(1, 0, 0, 'h0040 + k, 16'h0, "R5");
    acc(1, 0, 1, 'h00FC, 16'h0, "R5");

    acc(1, 1, 1, 'h0102, 16'h9999, "R6");
    acc(1, 0, 1, 'h0101, 16'h0, "R6");
    acc(1, 0, 1, 'h0100, 16'h0, "R6");
    acc(1, 0, 1, 'h0104, 16'h0, "R6");

    acc(1, 0, 0, 'h1400, 16'h0, "R7");
    acc(1, 1, 0, 'h1400, 16'h000F, "R7");
    acc(1, 1, 0, 'hFFFF, 16'h000F, "R7");
    acc(1, 0, 0, 'h0000, 16'h0, "R7");
    acc(1, 0, 0, 'h13FF, 16'h0, "R7");
    acc(1, 0, 0, 'h0FFF, 16'h0, "R7");

    acc(1, 1, 0, 'h0333, 16'h0006, "R8");
    acc(1, 1, 0, 'h0333, 16'h000D, "R8");
    acc(1, 0, 0, 'h0333, 16'h0, "R8");
    acc(1, 1, 1, 'h0108, 16'hCAFE, "R8");
    acc(1, 1, 1, 'h0108, 16'hF00D, "R8");
    acc(1, 0, 1, 'h0108, 16'h0, "R3");

    idle("R9");
    idle("R9");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d results never observed", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule